// File: doc/BRIEF.md
# Separable Sobel Gradient Unit

This block turns a stream of 8-bit, already-smoothed pixels into an 8-bit edge strength for each pixel. Each beat delivers three vertically adjacent pixels of one column: the current line and the two lines before it. The line memories that produce those taps sit outside the block. A beat is marked by `in_valid`, and idle cycles may appear anywhere in the stream.

Inside, each of the three taps first goes through a pass along the line. That pass keeps the two previous columns and forms two values: the signed difference between the outer columns, and the 1-2-1 weighted sum. A second pass then works across lines. It weights the three line differences 1-2-1 to give the horizontal gradient, and it subtracts the top weighted sum from the bottom one to give the vertical gradient. Each directional gradient is reduced to its magnitude and divided by four. The larger of the two magnitudes is the result. All scaling by two and by four is done by wiring.

The gradient of a beat belongs to the pixel one line up and one column left of that beat. A frame position tracker forces the output to zero whenever that 3x3 window reaches outside the frame. The pipeline runs every cycle, and a valid tag travels with the data through it.

Top module: `edge_grad_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid` is 0 and `out_grad` is 0.
- R2: Every beat accepted with `in_valid` high produces exactly one cycle of `out_valid` high, exactly 4 clock cycles later. Idle input cycles produce idle output cycles.
- R3: For each tap, the along-line pass forms the difference d = p(c) − p(c−2) as a 9-bit signed value. It also forms the sum s = p(c−2) + 2·p(c−1) + p(c) as a 10-bit unsigned value. Here c is the column of the current beat.
- R4: The across-line pass forms gx = d_top + 2·d_mid + d_bot and gy = s_bot − s_top, each as an 11-bit signed value, with no overflow for any input.
- R5: Each of gx and gy is reduced to floor(|g| / 4). The two's-complement magnitude is taken first, and the result fits in 8 bits.
- R6: When the output is not blanked, `out_grad` is the maximum of floor(|gx|/4) and floor(|gy|/4).
- R7: A beat whose row index is 0 or 1, or whose column index is 0 or 1, gives `out_grad` = 0. Row and column are counted in valid beats from the frame start.
- R8: The column history of each tap advances only on valid beats. Tap values presented on idle cycles have no effect on any later output.
- R9: The column index wraps to 0 after LINE_W beats and then advances the row. The row index wraps to 0 after FRAME_H lines, so the next frame starts blanked again with no gap needed.
- R10: Full-swing steps (0 to 255) across columns or across lines give 255 without any wrap of the intermediates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat qualifier for the three taps |
| tap_top | input | 8 | Pixel of the current column two lines above the current line |
| tap_mid | input | 8 | Pixel of the current column one line above the current line |
| tap_bot | input | 8 | Pixel of the current column on the current line |
| out_valid | output | 1 | Marks a gradient result, 4 cycles after its beat |
| out_grad | output | 8 | Gradient magnitude of the window centre |

## Verification
On the last pixel of a frame, the column wrap and the row wrap happen in the same cycle. The next beat after that, now at row 0 and column 0, must be blanked, while results from the previous frame are still draining from the pipeline. The bench sends frames back to back with no idle cycles, so this happens at every frame boundary. It checks that results from the old frame keep their computed values while the new frame's first two lines come out as zero. A second coincidence comes from idle cycles inserted inside a frame while garbage sits on the taps. Those bubbles must stall the column history but not the pipeline. They are judged by comparing the output value and its exact arrival cycle with arithmetic done in the bench.

// File: rtl/egu_pkg.sv
package egu_pkg;
    // pixel width and the widths that grow from it through the two passes
    localparam int unsigned PIX_W   = 8;
    localparam int unsigned DIF_W   = PIX_W + 1;
    localparam int unsigned SUM_W   = PIX_W + 2;
    localparam int unsigned GRD_W   = PIX_W + 3;
    localparam int unsigned TAPS    = 3;
    localparam int unsigned REACH   = TAPS - 1;
    localparam int unsigned LATENCY = 4;

    typedef logic [PIX_W-1:0]        pix_t;
    typedef logic signed [DIF_W-1:0] dif_t;
    typedef logic [SUM_W-1:0]        sum_t;
    typedef logic signed [GRD_W-1:0] grd_t;

    // bookkeeping bits that ride with the data
    typedef struct packed {
        logic vld;
        logic blank;
    } tag_t;

    // along-line pass result for one tap
    typedef struct packed {
        dif_t dif;
        sum_t sum;
    } row_res_t;

    // across-line pass result
    typedef struct packed {
        grd_t gx;
        grd_t gy;
    } grd_pair_t;

    // two's-complement magnitude, then divide by four by dropping two bits
    function automatic pix_t mag_quarter(input grd_t g);
        logic [GRD_W-1:0] a;
        a = g[GRD_W-1] ? -g : g;
        return a[PIX_W+1:2];
    endfunction
endpackage

// File: rtl/egu_pos_track.sv
module egu_pos_track
    import egu_pkg::*;
#(
    parameter int unsigned LINE_W  = 640,
    parameter int unsigned FRAME_H = 480
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic blank
);
    localparam int unsigned CW = $clog2(LINE_W);
    localparam int unsigned RW = $clog2(FRAME_H);

    logic [CW-1:0] col_q;
    logic [RW-1:0] row_q;
    logic          col_end;
    logic          row_end;

    assign col_end = (col_q == CW'(LINE_W - 1));
    assign row_end = (row_q == RW'(FRAME_H - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            row_q <= '0;
        end else if (adv) begin
            if (col_end) begin
                col_q <= '0;
                row_q <= row_end ? '0 : row_q + 1'b1;
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end

    // the window of this beat reaches outside the frame
    assign blank = (row_q < RW'(REACH)) || (col_q < CW'(REACH));

    // position only moves on valid beats
    assert_pos_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(col_q) && $stable(row_q)));

    // the last column of a line is followed by column 0
    assert_col_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (adv && col_end) |=> (col_q == '0));

    // the last pixel of a frame is followed by row 0
    assert_row_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (adv && col_end && row_end) |=> (row_q == '0));
endmodule

// File: rtl/egu_row_pass.sv
module egu_row_pass
    import egu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     adv,
    input  pix_t     px,
    output row_res_t res_q
);
    pix_t d1_q;
    pix_t d2_q;

    // column history, advanced on valid beats only
    always_ff @(posedge clk) begin
        if (rst) begin
            d1_q <= '0;
            d2_q <= '0;
        end else if (adv) begin
            d1_q <= px;
            d2_q <= d1_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.dif <= $signed({1'b0, px}) - $signed({1'b0, d2_q});
            res_q.sum <= SUM_W'(d2_q) + (SUM_W'(d1_q) << 1) + SUM_W'(px);
        end
    end

    assert_hist_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(d1_q) && $stable(d2_q)));

    // a flat neighbourhood gives no difference and four times the pixel
    assert_flat_row_R3: assert property (@(posedge clk) disable iff (rst)
        (px == d1_q && px == d2_q) |=>
            (res_q.dif == '0 && res_q.sum == (SUM_W'($past(px)) << 2)));
endmodule

// File: rtl/egu_col_pass.sv
module egu_col_pass
    import egu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  row_res_t  top,
    input  row_res_t  mid,
    input  row_res_t  bot,
    input  tag_t      tag_i,
    output grd_pair_t g_q,
    output tag_t      tag_q
);
    grd_t dt;
    grd_t dm;
    grd_t db;

    assign dt = GRD_W'($signed(top.dif));
    assign dm = GRD_W'($signed(mid.dif));
    assign db = GRD_W'($signed(bot.dif));

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q   <= '0;
            tag_q <= '0;
        end else begin
            g_q.gx <= dt + (dm <<< 1) + db;
            g_q.gy <= $signed(GRD_W'(bot.sum)) - $signed(GRD_W'(top.sum));
            tag_q  <= tag_i;
        end
    end

    // equal outer line sums cancel across lines
    assert_gy_cancel_R4: assert property (@(posedge clk) disable iff (rst)
        (top.sum == bot.sum) |=> (g_q.gy == '0));

    // identical line differences add to four times one of them
    assert_gx_scale_R4: assert property (@(posedge clk) disable iff (rst)
        (top.dif == mid.dif && mid.dif == bot.dif) |=>
            (g_q.gx == (GRD_W'($signed($past(mid.dif))) <<< 2)));
endmodule

// File: rtl/egu_mag_sel.sv
module egu_mag_sel
    import egu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  grd_pair_t g,
    input  tag_t      tag_i,
    output logic      out_vld,
    output pix_t      out_px
);
    pix_t ax_q;
    pix_t ay_q;
    tag_t tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ax_q  <= '0;
            ay_q  <= '0;
            tag_q <= '0;
        end else begin
            ax_q  <= mag_quarter(g.gx);
            ay_q  <= mag_quarter(g.gy);
            tag_q <= tag_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_px  <= '0;
        end else begin
            out_vld <= tag_q.vld;
            out_px  <= tag_q.blank ? '0 : ((ax_q > ay_q) ? ax_q : ay_q);
        end
    end

    // opposite gradients give equal magnitudes
    assert_abs_sym_R5: assert property (@(posedge clk) disable iff (rst)
        (g.gx == -g.gy) |=> (ax_q == ay_q));

    // an unblanked result dominates both magnitudes and equals one of them
    assert_max_pick_R6: assert property (@(posedge clk) disable iff (rst)
        $past(tag_q.vld && !tag_q.blank) |->
            (out_px >= $past(ax_q) && out_px >= $past(ay_q) &&
             (out_px == $past(ax_q) || out_px == $past(ay_q))));
endmodule

// File: rtl/edge_grad_unit.sv
module edge_grad_unit
    import egu_pkg::*;
#(
    parameter int unsigned LINE_W  = 640,
    parameter int unsigned FRAME_H = 480
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] tap_top,
    input  logic [PIX_W-1:0] tap_mid,
    input  logic [PIX_W-1:0] tap_bot,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_grad
);
    pix_t      taps [TAPS];
    row_res_t  rows [TAPS];
    logic      blank;
    tag_t      tag_s1;
    tag_t      tag_s2;
    grd_pair_t grads;

    assign taps[0] = tap_top;
    assign taps[1] = tap_mid;
    assign taps[2] = tap_bot;

    for (genvar k = 0; k < TAPS; k++) begin : g_row
        egu_row_pass u_row (
            .clk   (clk),
            .rst   (rst),
            .adv   (in_valid),
            .px    (taps[k]),
            .res_q (rows[k])
        );
    end

    egu_pos_track #(
        .LINE_W  (LINE_W),
        .FRAME_H (FRAME_H)
    ) u_pos (
        .clk   (clk),
        .rst   (rst),
        .adv   (in_valid),
        .blank (blank)
    );

    always_ff @(posedge clk) begin
        if (rst) tag_s1 <= '0;
        else     tag_s1 <= '{vld: in_valid, blank: blank};
    end

    egu_col_pass u_col (
        .clk   (clk),
        .rst   (rst),
        .top   (rows[0]),
        .mid   (rows[1]),
        .bot   (rows[2]),
        .tag_i (tag_s1),
        .g_q   (grads),
        .tag_q (tag_s2)
    );

    egu_mag_sel u_mag (
        .clk     (clk),
        .rst     (rst),
        .g       (grads),
        .tag_i   (tag_s2),
        .out_vld (out_valid),
        .out_px  (out_grad)
    );

    // cycles since reset, saturating, so that $past never reaches before reset
    logic [2:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)                         age_q <= '0;
        else if (age_q != 3'(LATENCY))   age_q <= age_q + 1'b1;
    end

    assert_valid_lat_R2: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3'(LATENCY)) |-> (out_valid == $past(in_valid, LATENCY)));

    assert_blank_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3'(LATENCY) && $past(in_valid && blank, LATENCY)) |->
            (out_grad == '0));

    assert_quiet_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_grad == '0));
endmodule

// File: tb/edge_grad_unit_tb_top.sv
module edge_grad_unit_tb_top;
    localparam int W   = 8;
    localparam int H   = 6;
    localparam int LAT = 4;
    localparam int NX  = 4096;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] t_top = '0;
    logic [7:0] t_mid = '0;
    logic [7:0] t_bot = '0;
    logic       out_valid;
    logic [7:0] out_grad;

    always #5 clk = ~clk;

    edge_grad_unit #(.LINE_W(W), .FRAME_H(H)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .tap_top   (t_top),
        .tap_mid   (t_mid),
        .tap_bot   (t_bot),
        .out_valid (out_valid),
        .out_grad  (out_grad)
    );

    int    ncyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    bit    exp_v [NX];
    int    exp_g [NX];
    string exp_r [NX];
    int    fr [H][W];
    logic [7:0] lf = 8'h5D;

    always @(posedge clk) ncyc <= ncyc + 1;

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // expected gradient for a beat at row r, column c (window rows r-2..r, cols c-2..c)
    function automatic int model(input int r, input int c);
        int d [3];
        int s [3];
        int gx, gy, ax, ay;
        if (r < 2 || c < 2) return 0;
        for (int k = 0; k < 3; k++) begin
            d[k] = fr[r-2+k][c] - fr[r-2+k][c-2];
            s[k] = fr[r-2+k][c-2] + 2 * fr[r-2+k][c-1] + fr[r-2+k][c];
        end
        gx = d[0] + 2 * d[1] + d[2];
        gy = s[2] - s[0];
        ax = iabs(gx) / 4;
        ay = iabs(gy) / 4;
        return (ax > ay) ? ax : ay;
    endfunction

    function automatic logic [7:0] tap_of(input int r, input int c);
        if (r < 0) return 8'(8'hA5 ^ (c * 29));
        return 8'(fr[r][c]);
    endfunction

    task automatic step_lf();
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    endtask

    task automatic fill(input int kind);
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                case (kind)
                    0: fr[r][c] = (r * 37 + c * 23) % 256;
                    1: fr[r][c] = (c < 4) ? 0 : 255;
                    2: fr[r][c] = (r < 3) ? 255 : 0;
                    default: begin step_lf(); fr[r][c] = int'(lf); end
                endcase
            end
        end
    endtask

    // send one frame; idle cycles carry garbage taps when bubbles are on
    task automatic run_frame(input string req, input bit bubbles);
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                step_lf();
                if (bubbles && lf[0]) begin
                    in_valid = 1'b0;
                    t_top = lf; t_mid = ~lf; t_bot = lf ^ 8'h3C;
                    @(negedge clk);
                end
                in_valid = 1'b1;
                t_top = tap_of(r - 2, c);
                t_mid = tap_of(r - 1, c);
                t_bot = tap_of(r, c);
                exp_v[ncyc + LAT] = 1'b1;
                exp_g[ncyc + LAT] = model(r, c);
                exp_r[ncyc + LAT] = (r < 2 || c < 2) ? ((r < 2 && req != "R3") ? "R9" : "R7") : req;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (chk_on && !done) begin
            n_chk++;
            if (out_valid !== exp_v[ncyc]) begin
                n_fail++;
                $display("FAIL R2 cycle %0d: out_valid=%0b expected %0b", ncyc, out_valid, exp_v[ncyc]);
            end else if (exp_v[ncyc]) begin
                n_chk++;
                if (out_grad !== 8'(exp_g[ncyc])) begin
                    n_fail++;
                    $display("FAIL %s cycle %0d: out_grad=%0d expected %0d",
                             exp_r[ncyc], ncyc, out_grad, exp_g[ncyc]);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < NX; i++) begin
            exp_v[i] = 1'b0;
            exp_g[i] = 0;
            exp_r[i] = "R2";
        end
        repeat (3) @(negedge clk);
        // R1: quiet outputs under reset
        n_chk++;
        if (out_valid !== 1'b0 || out_grad !== 8'd0) begin
            n_fail++;
            $display("FAIL R1: out_valid=%0b out_grad=%0d expected 0 0", out_valid, out_grad);
        end
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || out_grad !== 8'd0) begin
            n_fail++;
            $display("FAIL R1: out_valid=%0b out_grad=%0d expected 0 0 after release", out_valid, out_grad);
        end
        chk_on = 1'b1;
        fill(0); run_frame("R3", 1'b0);
        fill(1); run_frame("R10", 1'b0);
        fill(2); run_frame("R4", 1'b0);
        fill(3); run_frame("R8", 1'b1);
        fill(3); run_frame("R5", 1'b0);
        fill(3); run_frame("R6", 1'b1);
        repeat (LAT + 4) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule